// File: doc/BRIEF.md
# Multi-slot predicated branch resolver

This block sits in the flow-control stage of a wide-issue core. Each instruction bundle may carry up to four predicated branches, one per flow slot. Every branch names a bit of the predicate vector, a signed target offset and a short delay count. The offset comes either from an immediate literal or from a register operand. The resolver holds each branch in its slot until its delay has run out. At that point it reads the selected predicate bit and, among all slots that resolve true on the same clock edge, lets the lowest-numbered slot redirect fetch.

Targets are measured from the entry address of the current basic block, not from the branch itself. A redirect therefore moves the entry base to the new address. It also discards every branch still waiting from the block being left.

Top module: `branch_resolver`

## Requirements
- R1: A branch whose selected predicate bit is 0 when sampled produces no redirect and frees its slot. One whose bit is 1 is taken.
- R2: When several slots are taken on the same edge, only the lowest-numbered one redirects, and `redirect_slot` gives its index (0 to 3).
- R3: `redirect_addr` equals the entry base plus the winning offset, read as an OFS_W-bit two's-complement value and sign-extended to ADDR_W.
- R4: `issue_src` bit s selects the offset source for slot s: 0 takes `issue_lit`, 1 takes `issue_reg`.
- R5: A branch captured on edge E0 with delay d (4 bits) samples its predicate on edge E0+1+d, and the redirect is visible right after that edge. Predicate values at earlier edges have no effect; with d=0 the latency is one edge.
- R6: A redirect loads the entry base with the redirect address, and later offsets are added to that new base.
- R7: On a redirect, every other branch still pending is discarded and never redirects.
- R8: Issuing into a slot that is pending, not resolving on that edge and not flushed raises `issue_err` for one cycle. The new branch is dropped and the held branch is kept. A slot resolving on that edge accepts the new branch without error.
- R9: `redirect_valid` is a one-cycle pulse per taken winner.
- R10: While `rst_n` is low at an edge, all pending branches are cleared, the entry base becomes RESET_ADDR, and `redirect_valid`, `issue_err`, `redirect_addr` and `redirect_slot` become 0.
- R11: The slot count NUM_SLOTS is a parameter from 1 to 4. Slot 0 always exists and ranks highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld | input | NUM_SLOTS | Branch issued in slot s this cycle |
| issue_src | input | NUM_SLOTS | Offset source per slot: 0 literal, 1 register |
| issue_sel | input | NUM_SLOTS*$clog2(PRED_W) | Predicate bit index per slot |
| issue_lit | input | NUM_SLOTS*OFS_W | Literal offset per slot |
| issue_reg | input | NUM_SLOTS*OFS_W | Register-operand offset per slot |
| issue_dly | input | NUM_SLOTS*DLY_W | Delay count per slot |
| pred_vec | input | PRED_W | Predicate bits, read at resolution |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_addr | output | ADDR_W | Redirect target address |
| redirect_slot | output | 2 | Index of the winning slot |
| issue_err | output | 1 | Issue into an occupied slot was dropped |

## Verification
A branch with delay d is captured on one rising edge and resolves d+1 edges later. `redirect_valid`, `redirect_addr`, `redirect_slot` and the entry base all register on that resolving edge. `issue_err` registers on the same edge as the rejected issue. The bench drives inputs on falling edges and reads each result on the falling edge that follows the edge where the result is due. It also checks the edges just before and just after: a redirect one edge early or one edge late counts as a failure. Predicate bits are changed between those edges to show that only the value at the resolving edge counts.

// File: rtl/br_pkg.sv
// Shared definitions for the branch resolver.
// Assumes at most four flow slots, so a slot index always fits in two bits.
package br_pkg;
    localparam int MAX_SLOTS  = 4;
    localparam int SLOT_IDX_W = 2;

    // Offset source encoding carried on issue_src.
    typedef enum logic {
        SRC_LIT = 1'b0,
        SRC_REG = 1'b1
    } ofs_src_e;
endpackage

// File: rtl/br_slot.sv
// One flow slot: holds at most one pending branch and counts down its delay.
// It resolves when the count is zero. Assumes flush is asserted only on an
// edge where a redirect fires. A branch issued on that same edge belongs to
// the new block and is kept.
module br_slot #(
    parameter int SEL_W = 3,
    parameter int OFS_W = 12,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [SEL_W-1:0] issue_sel,
    input  logic [OFS_W-1:0] issue_ofs,
    input  logic [DLY_W-1:0] issue_dly,
    input  logic             flush,
    output logic             pend,
    output logic             due,
    output logic [SEL_W-1:0] sel,
    output logic [OFS_W-1:0] ofs,
    output logic             reject
);
    logic             pend_q;
    logic [DLY_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [OFS_W-1:0] ofs_q;
    logic             slot_free;
    logic             load;

    // Decide whether this edge may accept a new branch into the slot.
    always_comb begin
        due       = pend_q && (cnt_q == '0);
        slot_free = !pend_q || due || flush;
        load      = issue_vld && slot_free;
        reject    = issue_vld && !slot_free;
    end

    // Hold, count down, retire or replace the pending branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            sel_q  <= '0;
            ofs_q  <= '0;
        end else if (load) begin
            pend_q <= 1'b1;
            cnt_q  <= issue_dly;
            sel_q  <= issue_sel;
            ofs_q  <= issue_ofs;
        end else if (due || flush) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign pend = pend_q;
    assign sel  = sel_q;
    assign ofs  = ofs_q;

    // R5: a waiting branch loses exactly one count per edge.
    a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && (cnt_q != '0) && !flush |=> pend_q && (cnt_q == $past(cnt_q) - 1'b1));

    // R7: a flush with no new issue leaves the slot empty.
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !issue_vld |=> !pend_q);

    // R8: a rejected issue leaves the held branch untouched.
    a_r8_keep_held: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> pend_q && (sel_q == $past(sel_q)) && (ofs_q == $past(ofs_q)));
endmodule

// File: rtl/br_pick.sv
// Fixed-priority pick: the lowest-numbered requesting slot wins.
// Purely combinational. Assumes N is between 1 and 4.
module br_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic [1:0]   idx,
    output logic         any
);
    // Scan from the top so the lowest request is written last and wins.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = 2'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/branch_resolver.sv
// Multi-slot predicated branch resolver.
// Resolves up to NUM_SLOTS delayed predicated branches and picks the
// lowest-slot taken one. It adds that branch's signed offset to the current
// block entry base and emits a registered redirect. Assumes ADDR_W > OFS_W,
// PRED_W a power of two and 1 <= NUM_SLOTS <= 4.
module branch_resolver
    import br_pkg::*;
#(
    parameter int          NUM_SLOTS  = 4,
    parameter int          ADDR_W     = 32,
    parameter int          OFS_W      = 12,
    parameter int          PRED_W     = 8,
    parameter int          DLY_W      = 4,
    parameter logic [31:0] RESET_ADDR = 32'h0000_1000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_SLOTS-1:0]                 issue_vld,
    input  logic [NUM_SLOTS-1:0]                 issue_src,
    input  logic [NUM_SLOTS*$clog2(PRED_W)-1:0]  issue_sel,
    input  logic [NUM_SLOTS*OFS_W-1:0]           issue_lit,
    input  logic [NUM_SLOTS*OFS_W-1:0]           issue_reg,
    input  logic [NUM_SLOTS*DLY_W-1:0]           issue_dly,
    input  logic [PRED_W-1:0]                    pred_vec,
    output logic                                 redirect_valid,
    output logic [ADDR_W-1:0]                    redirect_addr,
    output logic [SLOT_IDX_W-1:0]                redirect_slot,
    output logic                                 issue_err
);
    localparam int SEL_W = $clog2(PRED_W);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [NUM_SLOTS-1:0] slot_due;
    logic [NUM_SLOTS-1:0] slot_pend;
    logic [NUM_SLOTS-1:0] slot_rej;
    logic [NUM_SLOTS-1:0] taken;
    logic [NUM_SLOTS-1:0] grant;
    logic [SEL_W-1:0]     slot_sel [NUM_SLOTS];
    logic [OFS_W-1:0]     slot_ofs [NUM_SLOTS];
    logic [SLOT_IDX_W-1:0] win_idx;
    logic                 fire;
    logic [ADDR_W-1:0]    entry_base_q;
    logic [OFS_W-1:0]     win_ofs;
    logic [ADDR_W-1:0]    next_addr;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [OFS_W-1:0] in_ofs;

        // Pick the offset source for this slot.
        always_comb begin
            in_ofs = (ofs_src_e'(issue_src[s]) == SRC_REG) ? issue_reg[s*OFS_W +: OFS_W]
                                                           : issue_lit[s*OFS_W +: OFS_W];
        end

        br_slot #(
            .SEL_W (SEL_W),
            .OFS_W (OFS_W),
            .DLY_W (DLY_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_vld (issue_vld[s]),
            .issue_sel (issue_sel[s*SEL_W +: SEL_W]),
            .issue_ofs (in_ofs),
            .issue_dly (issue_dly[s*DLY_W +: DLY_W]),
            .flush     (fire),
            .pend      (slot_pend[s]),
            .due       (slot_due[s]),
            .sel       (slot_sel[s]),
            .ofs       (slot_ofs[s]),
            .reject    (slot_rej[s])
        );

        // A resolving slot is taken when its selected predicate bit is set.
        always_comb taken[s] = slot_due[s] && pred_vec[slot_sel[s]];

        // R2: a granted slot has no taken slot below it.
        a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            grant[s] |-> ((taken & NUM_SLOTS'((1 << s) - 1)) == '0));
    end

    br_pick #(
        .N (NUM_SLOTS)
    ) u_pick (
        .req   (taken),
        .grant (grant),
        .idx   (win_idx),
        .any   (fire)
    );

    // Form the candidate redirect address from the winning offset.
    always_comb begin
        win_ofs   = slot_ofs[win_idx[$clog2(NUM_SLOTS > 1 ? NUM_SLOTS : 2)-1:0] % NUM_SLOTS];
        next_addr = entry_base_q + {{EXT_W{win_ofs[OFS_W-1]}}, win_ofs};
    end

    // Register the redirect outputs, the entry base and the issue error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_base_q   <= ADDR_W'(RESET_ADDR);
            redirect_valid <= 1'b0;
            redirect_addr  <= '0;
            redirect_slot  <= '0;
            issue_err      <= 1'b0;
        end else begin
            redirect_valid <= fire;
            issue_err      <= |slot_rej;
            if (fire) begin
                entry_base_q  <= next_addr;
                redirect_addr <= next_addr;
                redirect_slot <= win_idx;
            end
        end
    end

    // R2: at most one slot is granted, and only a taken one.
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~taken) == '0));

    // R1: with no taken slot, no redirect follows.
    a_r1_no_taken_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (taken == '0) |=> !redirect_valid);

    // R6: after a redirect the entry base equals the redirect address.
    a_r6_base_follows: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (entry_base_q == redirect_addr));

    // R8: an error flag only follows an issue.
    a_r8_err_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_err |-> $past(|issue_vld));

    // R11: a reported slot index names an existing slot.
    a_r11_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (int'(redirect_slot) < NUM_SLOTS));
endmodule

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
    localparam int          NS    = 4;
    localparam int          AW    = 32;
    localparam int          OW    = 12;
    localparam int          PW    = 8;
    localparam int          DW    = 4;
    localparam int          SW    = 3;
    localparam logic [31:0] RADDR = 32'h0000_1000;

    typedef struct packed {
        logic [3:0]  vld;
        logic [3:0]  src;
        logic [11:0] sel;
        logic [47:0] ofs;
        logic [7:0]  pred;
        logic        ev;
        logic [1:0]  es;
    } vec_t;

    // Zero-delay bundles: issue, predicate, expected winner.
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 4'b0000, {3'd0,3'd0,3'd0,3'd2}, {12'h0,12'h0,12'h0,12'h010}, 8'h04, 1'b1, 2'd0},
        '{4'b0001, 4'b0000, {3'd0,3'd0,3'd0,3'd2}, {12'h0,12'h0,12'h0,12'h050}, 8'hFB, 1'b0, 2'd0},
        '{4'b0110, 4'b0000, {3'd0,3'd3,3'd4,3'd0}, {12'h0,12'h030,12'h020,12'h0}, 8'hFF, 1'b1, 2'd1},
        '{4'b1001, 4'b1000, {3'd5,3'd0,3'd0,3'd1}, {12'hFF0,12'h0,12'h0,12'h111}, 8'h20, 1'b1, 2'd3},
        '{4'b1111, 4'b0101, {3'd7,3'd6,3'd5,3'd4}, {12'h400,12'h300,12'h200,12'h004}, 8'hF0, 1'b1, 2'd0},
        '{4'b0100, 4'b0100, {3'd0,3'd7,3'd0,3'd0}, {12'h0,12'h100,12'h0,12'h0}, 8'h80, 1'b1, 2'd2},
        '{4'b0000, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, {12'h0,12'h0,12'h0,12'h0}, 8'hFF, 1'b0, 2'd0},
        '{4'b1110, 4'b0000, {3'd1,3'd1,3'd1,3'd0}, {12'h7,12'h6,12'h5,12'h0}, 8'hFD, 1'b0, 2'd0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NS-1:0]       issue_vld = '0;
    logic [NS-1:0]       issue_src = '0;
    logic [NS*SW-1:0]    issue_sel = '0;
    logic [NS*OW-1:0]    issue_lit = '0;
    logic [NS*OW-1:0]    issue_reg = '0;
    logic [NS*DW-1:0]    issue_dly = '0;
    logic [PW-1:0]       pred_vec = '0;
    logic                redirect_valid;
    logic [AW-1:0]       redirect_addr;
    logic [1:0]          redirect_slot;
    logic                issue_err;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_base;

    always #10 clk = ~clk;

    branch_resolver #(
        .NUM_SLOTS (NS), .ADDR_W (AW), .OFS_W (OW), .PRED_W (PW),
        .DLY_W (DW), .RESET_ADDR (RADDR)
    ) uut (
        .clk (clk), .rst_n (rst_n), .issue_vld (issue_vld), .issue_src (issue_src),
        .issue_sel (issue_sel), .issue_lit (issue_lit), .issue_reg (issue_reg),
        .issue_dly (issue_dly), .pred_vec (pred_vec), .redirect_valid (redirect_valid),
        .redirect_addr (redirect_addr), .redirect_slot (redirect_slot), .issue_err (issue_err)
    );

    function automatic logic [31:0] sext(input logic [11:0] o);
        return {{20{o[11]}}, o};
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input int s, input logic [2:0] sel, input logic [11:0] ofs,
                       input logic src, input logic [3:0] dly);
        issue_vld[s]          = 1'b1;
        issue_src[s]          = src;
        issue_sel[s*SW +: SW] = sel;
        issue_lit[s*OW +: OW] = src ? ~ofs : ofs;
        issue_reg[s*OW +: OW] = src ? ofs : ~ofs;
        issue_dly[s*DW +: DW] = dly;
    endtask

    task automatic expect_none(input string req);
        check(redirect_valid == 1'b0, req, 32'(redirect_valid), 32'd0);
    endtask

    task automatic expect_hit(input string req, input logic [1:0] slot, input logic [11:0] ofs);
        logic [31:0] ea;
        ea = exp_base + sext(ofs);
        check(redirect_valid == 1'b1, req, 32'(redirect_valid), 32'd1);
        check(redirect_addr == ea, req, redirect_addr, ea);
        check(redirect_slot == slot, req, 32'(redirect_slot), 32'(slot));
        exp_base = ea;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state.
        @(negedge clk);
        step();
        step();
        check(redirect_valid == 0 && issue_err == 0, "R10 reset flags", {redirect_valid, issue_err}, 0);
        check(redirect_addr == 0 && redirect_slot == 0, "R10 reset outputs", redirect_addr, 0);
        rst_n = 1'b1;
        exp_base = RADDR;
        step();

        // R1 R2 R3 R4 R6 R9: table of zero-delay bundles.
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < NS; s++) begin
                if (VECS[v].vld[s])
                    put(s, VECS[v].sel[s*3 +: 3], VECS[v].ofs[s*12 +: 12], VECS[v].src[s], 4'd0);
            end
            pred_vec = VECS[v].pred;
            step();
            issue_vld = '0;
            check(issue_err == 0, "R8 no error on free slots", 32'(issue_err), 0);
            step();
            if (VECS[v].ev)
                expect_hit("R1 R2 R3 R4 R6 table winner", VECS[v].es,
                           VECS[v].ofs[VECS[v].es*12 +: 12]);
            else
                expect_none("R1 table no redirect");
            step();
            expect_none("R9 pulse one cycle");
        end

        // R5: predicate low until the resolving edge still redirects (delay 3).
        pred_vec = 8'h00;
        put(0, 3'd0, 12'h008, 1'b0, 4'd3);
        step();
        issue_vld = '0;
        step(); expect_none("R5 early edge 1");
        step(); expect_none("R5 early edge 2");
        step(); expect_none("R5 early edge 3");
        pred_vec = 8'h01;
        step(); expect_hit("R5 delayed resolve", 2'd0, 12'h008);
        step(); expect_none("R9 delayed pulse");

        // R5: predicate high early, low at the resolving edge (delay 2).
        put(0, 3'd0, 12'h00C, 1'b0, 4'd2);
        step();
        issue_vld = '0;
        step(); expect_none("R5 early edge");
        pred_vec = 8'h00;
        step(); expect_none("R5 late false");
        step(); expect_none("R1 slot freed");

        // R7: redirect flushes a pending branch in another slot.
        pred_vec = 8'h01;
        put(0, 3'd0, 12'h040, 1'b0, 4'd2);
        put(1, 3'd0, 12'h060, 1'b0, 4'd0);
        step();
        issue_vld = '0;
        step(); expect_hit("R7 first redirect", 2'd1, 12'h060);
        step(); expect_none("R7 flushed edge 2");
        step(); expect_none("R7 flushed edge 3");

        // R8: issue into an occupied slot is dropped and flagged.
        pred_vec = 8'h08;
        put(0, 3'd3, 12'h0A0, 1'b0, 4'd5);
        step();
        put(0, 3'd3, 12'h0B0, 1'b0, 4'd0);
        step();
        issue_vld = '0;
        check(issue_err == 1, "R8 error flagged", 32'(issue_err), 1);
        step();
        check(issue_err == 0, "R8 error one cycle", 32'(issue_err), 0);
        expect_none("R8 dropped branch silent");
        step(); expect_none("R8 wait 3");
        step(); expect_none("R8 wait 4");
        step(); expect_none("R8 wait 5");
        step(); expect_hit("R8 held branch kept", 2'd0, 12'h0A0);

        // R8: a slot resolving on the issue edge accepts the new branch.
        pred_vec = 8'h08;
        put(0, 3'd1, 12'h0C0, 1'b0, 4'd0);
        step();
        put(0, 3'd3, 12'h0D0, 1'b0, 4'd0);
        step();
        issue_vld = '0;
        check(issue_err == 0, "R8 resolving slot accepts", 32'(issue_err), 0);
        expect_none("R1 false resolve");
        step(); expect_hit("R8 replacement resolves", 2'd0, 12'h0D0);

        // R10: reset during a pending branch clears it and restores the base.
        put(0, 3'd3, 12'h010, 1'b0, 4'd3);
        step();
        issue_vld = '0;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        exp_base = RADDR;
        expect_none("R10 reset clears output");
        for (int k = 0; k < 4; k++) begin
            step();
            expect_none("R10 pending cleared");
        end
        put(2, 3'd3, 12'h020, 1'b1, 4'd0);
        step();
        issue_vld = '0;
        step(); expect_hit("R10 R11 base restored", 2'd2, 12'h020);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule